// File: doc/BRIEF.md
# Seconds Countdown Alarm

A relative alarm that counts whole seconds down to zero. The host loads a number of seconds over a simple register bus. While counting is enabled, each one-cycle pulse on the seconds-tick input takes one off the remaining count. When the count steps from one to zero, a sticky pending flag is set and the count stays at zero.

The pending flag drives two outputs, each through its own gate. One is an interrupt request, gated by an interrupt-enable bit. The other is a wake-up request, gated by a wake-up configuration bit. Software clears the flag by writing a one to bit 0 of the status register. Writing zero to the load register cancels a countdown in progress.

A load written while counting is disabled is held. The countdown starts from that value once counting is enabled.

Top module: `alarm_countdown`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and both irq and wake are low.
- R2: A bus write to the load register (offset 0x00) sets the remaining count (offset 0x04) to the written value from the next cycle on. The load register reads back the value written.
- R3: With the run bit (bit 0 of offset 0x08) set and the count nonzero, each cycle with sec_tick high lowers the count by exactly one. A cycle without a tick, or with run clear, leaves the count unchanged.
- R4: A tick that moves the count from 1 to 0 sets the pending flag (bit 0 of offset 0x10). Later ticks leave the count at 0 and leave the flag as it is.
- R5: Writing 0 to the load register makes the count 0 without setting the pending flag.
- R6: A write to the status offset with bit 0 set clears the pending flag. A status write with bit 0 clear has no effect.
- R7: When a 1-to-0 step and a clearing status write fall in the same cycle, the pending flag ends up set.
- R8: irq is high exactly when the pending flag and the interrupt-enable bit (bit 0 of offset 0x0C) are both set.
- R9: wake is high exactly when the pending flag and the wake-up bit (bit 0 of offset 0x14) are both set.
- R10: A value loaded while run is clear is kept through any number of ticks. It counts down once run is set.
- R11: A load write in the same cycle as a tick takes priority. The count takes the written value, it is not decremented, and no pending flag is raised.
- R12: Reads of any offset other than the six listed return 0. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
The bench targets the exact step from one to zero. A design that fires at the wrong value would set pending one second early or late, or leave the count wrapped to all ones. It also drives a tick in the same cycle as a clearing write, and a tick in the same cycle as a load. A wrong priority loses the alarm in the first case, and in the second it decrements the freshly loaded value or raises a false alarm. Loads are written while counting is off, cancelled with zero, and mixed with random writes to unused offsets, so that a design that drops a parked load, alarms on cancel, or aliases addresses shows up as a wrong readback or a stray irq or wake.

// File: rtl/alarm_pkg.sv
// Package: shared register offsets and control-bit indices for the
// seconds countdown alarm. Assumes a 6-bit byte-offset bus.
package alarm_pkg;
    localparam int ADDR_W  = 6;
    localparam int NUM_CTL = 3;

    localparam logic [ADDR_W-1:0] A_LOAD   = 6'h00;
    localparam logic [ADDR_W-1:0] A_REMAIN = 6'h04;
    localparam logic [ADDR_W-1:0] A_RUN    = 6'h08;
    localparam logic [ADDR_W-1:0] A_IRQEN  = 6'h0C;
    localparam logic [ADDR_W-1:0] A_STATUS = 6'h10;
    localparam logic [ADDR_W-1:0] A_WAKE   = 6'h14;

    typedef enum int {
        CTL_RUN  = 0,
        CTL_IRQ  = 1,
        CTL_WAKE = 2
    } ctl_idx_e;

    // Map a control-bit index to its register offset.
    function automatic logic [ADDR_W-1:0] ctl_addr(input int idx);
        case (idx)
            CTL_RUN:  return A_RUN;
            CTL_IRQ:  return A_IRQEN;
            default:  return A_WAKE;
        endcase
    endfunction
endpackage

// File: rtl/alarm_regs.sv
// alarm_regs: register file and read mux of the countdown alarm.
// It holds the load value and the three single-bit controls (run,
// interrupt enable, wake enable). It decodes the load strobe and the
// write-one-to-clear request. Assumes single-cycle writes and a
// combinational read path.
module alarm_regs #(
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [alarm_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic [DATA_W-1:0]          remaining,
    input  logic                       pending,
    output logic                       load_wr,
    output logic [DATA_W-1:0]          load_val,
    output logic                       run_en,
    output logic                       irq_en,
    output logic                       wake_en,
    output logic                       clr_req,
    output logic [DATA_W-1:0]          bus_rdata
);
    import alarm_pkg::*;

    localparam logic [DATA_W-1:0] ZERO = '0;

    logic [DATA_W-1:0]  load_q;
    logic [NUM_CTL-1:0] ctl_q;

    // Decode the strobes that other blocks act on.
    always_comb begin
        load_wr = bus_wr && (bus_addr == A_LOAD);
        clr_req = bus_wr && (bus_addr == A_STATUS) && bus_wdata[0];
    end

    // Hold the last value written to the load register.
    always_ff @(posedge clk) begin
        if (!rst_n)       load_q <= ZERO;
        else if (load_wr) load_q <= bus_wdata;
    end

    // Update each single-bit control from bit 0 of its own offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            for (int i = 0; i < NUM_CTL; i++) begin
                if (bus_wr && (bus_addr == ctl_addr(i)))
                    ctl_q[i] <= bus_wdata[0];
            end
        end
    end

    assign load_val = bus_wdata;
    assign run_en   = ctl_q[CTL_RUN];
    assign irq_en   = ctl_q[CTL_IRQ];
    assign wake_en  = ctl_q[CTL_WAKE];

    // Select read data. Unmapped offsets read zero.
    always_comb begin
        bus_rdata = ZERO;
        case (bus_addr)
            A_LOAD:   bus_rdata = load_q;
            A_REMAIN: bus_rdata = remaining;
            A_RUN:    bus_rdata = {{(DATA_W-1){1'b0}}, ctl_q[CTL_RUN]};
            A_IRQEN:  bus_rdata = {{(DATA_W-1){1'b0}}, ctl_q[CTL_IRQ]};
            A_STATUS: bus_rdata = {{(DATA_W-1){1'b0}}, pending};
            A_WAKE:   bus_rdata = {{(DATA_W-1){1'b0}}, ctl_q[CTL_WAKE]};
            default:  bus_rdata = ZERO;
        endcase
    end
endmodule

// File: rtl/alarm_counter.sv
// alarm_counter: the seconds down-counter. A load write replaces the
// count and wins over a tick in the same cycle. While run is set, a tick
// lowers a nonzero count by one. The counter stops at zero. It emits a
// one-cycle expire pulse on the step from one to zero. Assumes sec_tick
// is a one-cycle pulse synchronous to clk.
module alarm_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              run_en,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] remaining,
    output logic              expire
);
    localparam logic [DATA_W-1:0] ZERO = '0;
    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);

    logic [DATA_W-1:0] cnt_q;
    logic              step;

    // Decide whether this cycle counts, and whether it reaches zero.
    always_comb begin
        step   = run_en && sec_tick && (cnt_q != ZERO) && !load_wr;
        expire = step && (cnt_q == ONE);
    end

    // Load, decrement or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= ZERO;
        else if (load_wr) cnt_q <= load_val;
        else if (step)    cnt_q <= cnt_q - ONE;
    end

    assign remaining = cnt_q;
endmodule

// File: rtl/alarm_flag.sv
// alarm_flag: sticky pending flag with its two output gates. Setting has
// priority over a write-one-to-clear in the same cycle. Assumes expire
// and clr_req are single-cycle strobes.
module alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_req,
    input  logic irq_en,
    input  logic wake_en,
    output logic pending,
    output logic irq,
    output logic wake
);
    logic pend_q;

    // Set on expiry, clear on request. Set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (expire)  pend_q <= 1'b1;
        else if (clr_req) pend_q <= 1'b0;
    end

    // Gate the flag onto the interrupt and wake-up requests.
    always_comb begin
        irq  = pend_q && irq_en;
        wake = pend_q && wake_en;
    end

    assign pending = pend_q;
endmodule

// File: rtl/alarm_countdown.sv
// alarm_countdown: top of the seconds countdown alarm. It ties the
// register file, the down-counter and the pending flag together.
// Assumes a single clock domain, with the seconds tick already
// synchronised to clk.
module alarm_countdown #(
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sec_tick,
    input  logic                         bus_wr,
    input  logic [alarm_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic                         irq,
    output logic                         wake
);
    logic [DATA_W-1:0] remaining;
    logic [DATA_W-1:0] load_val;
    logic              pending;
    logic              load_wr;
    logic              run_en;
    logic              irq_en;
    logic              wake_en;
    logic              clr_req;
    logic              expire;

    alarm_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .remaining (remaining),
        .pending   (pending),
        .load_wr   (load_wr),
        .load_val  (load_val),
        .run_en    (run_en),
        .irq_en    (irq_en),
        .wake_en   (wake_en),
        .clr_req   (clr_req),
        .bus_rdata (bus_rdata)
    );

    alarm_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .run_en    (run_en),
        .load_wr   (load_wr),
        .load_val  (load_val),
        .remaining (remaining),
        .expire    (expire)
    );

    alarm_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .clr_req (clr_req),
        .irq_en  (irq_en),
        .wake_en (wake_en),
        .pending (pending),
        .irq     (irq),
        .wake    (wake)
    );
endmodule

// File: rtl/alarm_countdown_chk.sv
// alarm_countdown_chk: temporal checks on the countdown alarm. The
// strobes are decoded again here from the bus ports. Attached to the
// top module by the bind at the end of this file.
module alarm_countdown_chk #(
    parameter int DATA_W = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         sec_tick,
    input logic                         bus_wr,
    input logic [alarm_pkg::ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0]            bus_wdata,
    input logic                         irq,
    input logic                         wake,
    input logic [DATA_W-1:0]            remaining,
    input logic                         pending,
    input logic                         run_en,
    input logic                         irq_en,
    input logic                         wake_en
);
    import alarm_pkg::*;

    localparam logic [DATA_W-1:0] ZERO = '0;
    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);

    logic c_load, c_clr, c_last;
    always_comb begin
        c_load = bus_wr && (bus_addr == A_LOAD);
        c_clr  = bus_wr && (bus_addr == A_STATUS) && bus_wdata[0];
        c_last = run_en && sec_tick && !c_load && (remaining == ONE);
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        c_load |=> remaining == $past(bus_wdata));

    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_en && sec_tick && !c_load && remaining != ZERO
        |=> remaining == $past(remaining) - ONE);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick && !c_load |=> $stable(remaining));

    p_expire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        c_last |=> pending && remaining == ZERO);

    p_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        remaining == ZERO && !c_load |=> remaining == ZERO);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !c_clr |=> pending);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c_clr && !c_last |=> !pending);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c_last && c_clr |=> pending);

    p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pending && irq_en);

    p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> pending && wake_en);

    p_load_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        c_load |=> $stable(pending));
endmodule

bind alarm_countdown alarm_countdown_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .wake      (wake),
    .remaining (remaining),
    .pending   (pending),
    .run_en    (run_en),
    .irq_en    (irq_en),
    .wake_en   (wake_en)
);

// File: tb/tb_alarm_countdown.sv
`timescale 1ns/1ps
module tb_alarm_countdown;
    localparam logic [5:0] ADR_LOAD = 6'h00, ADR_REM = 6'h04, ADR_RUN = 6'h08,
                           ADR_IE = 6'h0C, ADR_STAT = 6'h10, ADR_WAKE = 6'h14,
                           ADR_NONE = 6'h3C;

    logic        clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wake;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] m_load = 0, m_cnt = 0;
    logic        m_run = 0, m_ie = 0, m_we = 0, m_pend = 0;

    alarm_countdown dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wake(wake)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_irq();  return m_pend && m_ie; endfunction
    function automatic logic exp_wake(); return m_pend && m_we; endfunction

    // Reference update for one clock edge, written from the requirements.
    task automatic model(input logic wr, input logic [5:0] a, input logic [31:0] d, input logic t);
        logic lw, ex;
        lw = wr && a == ADR_LOAD;
        ex = m_run && t && !lw && m_cnt == 32'd1;
        if (lw) begin m_cnt = d; m_load = d; end
        else if (m_run && t && m_cnt != 0) m_cnt = m_cnt - 1;
        if (wr && a == ADR_RUN)  m_run = d[0];
        if (wr && a == ADR_IE)   m_ie  = d[0];
        if (wr && a == ADR_WAKE) m_we  = d[0];
        if (ex) m_pend = 1'b1;
        else if (wr && a == ADR_STAT && d[0]) m_pend = 1'b0;
    endtask

    // One clock: drive at negedge, update the model at posedge, return at negedge.
    task automatic step(input logic wr, input logic [5:0] a, input logic [31:0] d, input logic t);
        bus_wr = wr; bus_addr = a; bus_wdata = d; sec_tick = t;
        @(posedge clk);
        model(wr, a, d, t);
        @(negedge clk);
        bus_wr = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(ADR_REM, v);  check({tag, " remaining"}, v, m_cnt);
        rd(ADR_STAT, v); check({tag, " pending"}, v, {31'b0, m_pend});
        rd(ADR_LOAD, v); check({tag, " load readback"}, v, m_load);
        check({tag, " irq R8"}, {31'b0, irq}, {31'b0, exp_irq()});
        check({tag, " wake R9"}, {31'b0, wake}, {31'b0, exp_wake()});
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1: reset state
        rd(ADR_LOAD, v); check("R1 load", v, 0);
        rd(ADR_REM, v);  check("R1 remaining", v, 0);
        rd(ADR_RUN, v);  check("R1 run", v, 0);
        rd(ADR_IE, v);   check("R1 irq enable", v, 0);
        rd(ADR_STAT, v); check("R1 pending", v, 0);
        rd(ADR_WAKE, v); check("R1 wake enable", v, 0);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 wake", {31'b0, wake}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R10: load while stopped is retained through ticks
        step(1, ADR_LOAD, 32'd3, 0);
        check_all("R2 load");
        for (int i = 0; i < 4; i++) step(0, ADR_REM, 0, 1);
        check_all("R10 parked");
        step(1, ADR_IE, 1, 0);
        step(1, ADR_RUN, 1, 0);
        // R3: decrement per tick, hold without tick
        step(0, ADR_REM, 0, 1);
        check_all("R3 first tick");
        step(0, ADR_REM, 0, 0);
        check_all("R3 hold");
        step(0, ADR_REM, 0, 1);
        check_all("R3 second tick");
        // R4: reaching zero sets pending, then stays put
        step(0, ADR_REM, 0, 1);
        check_all("R4 expire");
        rd(ADR_STAT, v); check("R4 pending set", v, 1);
        check("R8 irq asserted", {31'b0, irq}, 1);
        check("R9 wake gated off", {31'b0, wake}, 0);
        for (int i = 0; i < 3; i++) step(0, ADR_REM, 0, 1);
        check_all("R4 floor");
        step(1, ADR_WAKE, 1, 0);
        check("R9 wake asserted", {31'b0, wake}, 1);
        step(1, ADR_IE, 0, 0);
        check("R8 irq gated off", {31'b0, irq}, 0);
        // R6: clear semantics
        step(1, ADR_STAT, 32'hFFFF_FFFE, 0);
        rd(ADR_STAT, v); check("R6 write zero ignored", v, 1);
        step(1, ADR_STAT, 1, 0);
        rd(ADR_STAT, v); check("R6 write one clears", v, 0);
        check("R9 wake drops", {31'b0, wake}, 0);
        // R7: expiry and clear in the same cycle
        step(1, ADR_LOAD, 1, 0);
        step(1, ADR_STAT, 1, 1);
        rd(ADR_STAT, v); check("R7 set wins", v, 1);
        step(1, ADR_STAT, 1, 0);
        // R5: cancel by writing zero
        step(1, ADR_LOAD, 2, 0);
        step(1, ADR_LOAD, 0, 0);
        for (int i = 0; i < 3; i++) step(0, ADR_REM, 0, 1);
        rd(ADR_REM, v);  check("R5 cancelled count", v, 0);
        rd(ADR_STAT, v); check("R5 no pending", v, 0);
        // R11: load in the same cycle as the final tick
        step(1, ADR_LOAD, 1, 0);
        step(1, ADR_LOAD, 5, 1);
        rd(ADR_REM, v);  check("R11 load wins", v, 5);
        rd(ADR_STAT, v); check("R11 no pending", v, 0);
        // R12: unmapped offset
        step(1, ADR_NONE, 32'hFFFF_FFFF, 1);
        rd(ADR_NONE, v); check("R12 unmapped reads zero", v, 0);
        check_all("R12 unmapped write");

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int op;
            logic [31:0] d;
            logic t;
            op = $urandom_range(0, 11);
            t  = 1'($urandom_range(0, 1));
            d  = $urandom;
            case (op)
                0, 1: step(1, ADR_LOAD, ($urandom_range(0, 19) == 0) ? d : 32'($urandom_range(0, 4)), t);
                2:    step(1, ADR_RUN, {31'b0, $urandom_range(0, 3) != 0}, t);
                3:    step(1, ADR_IE, d, t);
                4:    step(1, ADR_WAKE, d, t);
                5:    step(1, ADR_STAT, d, t);
                6:    step(1, 6'(4 * $urandom_range(6, 15)), d, t);
                default: step(0, ADR_REM, 0, t);
            endcase
            check_all("R3 R4 R6 R7 R11 random");
        end

        done = 1;
        summary();
        $finish;
    end
endmodule